// File: doc/BRIEF.md
# Circular Bus-Word Staging Buffer

This block sits between a refill engine and a consumer that drives a byte-wide parallel bus. Application bytes arrive one per cycle on a valid/ready source port. Each byte is turned into a 9-bit bus word made of the byte and an odd-parity bit, and the word is stored in a 256-slot circular ring. The consumer pulls one word per request and gets it on the next cycle.

Writing is bounded by a fill limit, which sits a fixed distance ahead of the write position. The ring raises a half-drained flag after the consumer takes slot 127 and a fully-drained flag after slot 255. Each acknowledged flag moves the fill limit forward by half the ring. If both flags are pending at the same moment, the consumer has lapped the refill side. The block then flags an overrun and stops the transfer.

A refill that ends before the limit leaves a poisoned word after its last byte, so a consumer that runs ahead shows a parity error on the bus. Such a short refill also locks out further writes until the consumer side is restarted.

Top module: `bus_word_stager`

## Requirements
- R1: After reset, src_ready is 1, and rd_valid, half_evt, full_evt, overrun and incomplete are all 0.
- R2: A read request returns, on the cycle after the request edge, rd_valid=1 and rd_word = {parity, byte}, where bit 8 is the XNOR-reduction of the byte (odd parity over all 9 bits) and bits 7:0 are the byte. Words come back in the order they were written.
- R3: The number of bytes accepted equals the fill limit minus the write position. After reset or restart this is exactly 256. src_ready is 0 once the limit is reached.
- R4: Each accepted drain_ack moves the fill limit forward by 128, which admits exactly 128 more bytes.
- R5: half_evt rises on the cycle after the read of slot 127, and full_evt rises on the cycle after the read of slot 255. Both stay set until drain_ack, which clears half_evt first if it is set, and otherwise clears full_evt.
- R6: If half_evt and full_evt would both be pending, overrun goes to 1 on that same cycle. After that, src_ready is 0, read requests return rd_valid=0, drain_ack is ignored, and overrun stays set until restart.
- R7: When a byte with src_last=1 is accepted and the slot after it is not at the fill limit, that next slot is written with 9'h000, which is the word for byte 0x00 with its parity bit inverted.
- R8: Such a short refill sets incomplete to 1. While incomplete is set, src_ready is 0 even after drain_ack. A last byte that lands exactly on the limit leaves incomplete at 0.
- R9: restart clears incomplete, overrun, half_evt and full_evt, and sets the write position, the read position and the fill limit to 0, 0 and 256.
- R10: drain_ack with no drain flag pending has no effect on the fill limit.
- R11: Both the read and write positions wrap modulo 256, so reading continues at slot 0 after slot 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 1 | Source byte offered |
| src_byte | input | 8 | Source data byte |
| src_last | input | 1 | Byte is the last one pending in this refill |
| src_ready | output | 1 | Byte is taken on this edge if src_valid is 1 |
| drain_ack | input | 1 | Refill side services one drain flag |
| restart | input | 1 | Restart consumer and clear window state |
| rd_req | input | 1 | Consumer asks for the next word |
| rd_valid | output | 1 | rd_word carries a returned word |
| rd_word | output | 9 | Bus word: parity in bit 8, data in bits 7:0 |
| half_evt | output | 1 | First half of ring drained, pending |
| full_evt | output | 1 | Second half of ring drained, pending |
| overrun | output | 1 | Both drain flags pending; transfer aborted |
| incomplete | output | 1 | Last refill stopped short of the limit |

## Verification
A read word and the drain flags it may set both appear one cycle after the rd_req edge, since both come from registers loaded at that edge. src_ready, incomplete and overrun follow registered state, so their effect is visible in the cycle after the write, ack or restart edge that caused it. The bench drives every input pulse for exactly one rising edge. It then samples on the next falling edge, so every comparison falls in the first cycle where the result is due. A byte counts as accepted only if src_ready was high at the falling edge before the edge that takes it.

// File: rtl/stagebuf_pkg.sv
package stagebuf_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned WORD_W = BYTE_W + 1;

    typedef struct packed {
        logic              par;
        logic [BYTE_W-1:0] data;
    } bus_word_t;

    // odd parity across all nine bits
    function automatic bus_word_t encode_byte(input logic [BYTE_W-1:0] b);
        bus_word_t w;
        w.data = b;
        w.par  = ~^b;
        return w;
    endfunction

    // word for byte zero with the parity bit flipped
    function automatic bus_word_t poison_word();
        bus_word_t w;
        w     = encode_byte('0);
        w.par = ~w.par;
        return w;
    endfunction

endpackage

// File: rtl/sb_ring.sv
module sb_ring
    import stagebuf_pkg::*;
#(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned IDXW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            wa_en,
    input  logic [IDXW-1:0] wa_addr,
    input  bus_word_t       wa_word,
    input  logic            wb_en,
    input  logic [IDXW-1:0] wb_addr,
    input  bus_word_t       wb_word,
    input  logic            rd_en,
    input  logic [IDXW-1:0] rd_addr,
    output bus_word_t       rd_word
);

    bus_word_t slots [DEPTH];
    bus_word_t rd_q;

    always_ff @(posedge clk) begin
        if (wa_en) slots[wa_addr] <= wa_word;
        if (wb_en) slots[wb_addr] <= wb_word;
        if (rd_en) rd_q <= slots[rd_addr];
    end

    assign rd_word = rd_q;

endmodule

// File: rtl/sb_fill_ctrl.sv
module sb_fill_ctrl
    import stagebuf_pkg::*;
#(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned IDXW = $clog2(DEPTH),
    localparam int unsigned PTRW = IDXW + 2,
    localparam int unsigned HALF = DEPTH / 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            restart,
    input  logic            aborted,
    input  logic            window_adv,
    input  logic            src_valid,
    input  logic            src_last,
    output logic            src_ready,
    output logic            wr_en,
    output logic [IDXW-1:0] wr_addr,
    output logic            poison_en,
    output logic [IDXW-1:0] poison_addr,
    output logic            incomplete
);

    logic [PTRW-1:0] wr_ptr, lim_ptr, room, nxt_ptr;
    logic            short_q;

    assign room      = lim_ptr - wr_ptr;
    assign nxt_ptr   = wr_ptr + PTRW'(1);
    assign src_ready = !short_q && !aborted && !restart && (room != '0);
    assign wr_en     = src_valid && src_ready;
    assign wr_addr   = wr_ptr[IDXW-1:0];
    assign poison_en = wr_en && src_last && (room != PTRW'(1));
    assign poison_addr = nxt_ptr[IDXW-1:0];
    assign incomplete  = short_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            wr_ptr  <= '0;
            lim_ptr <= PTRW'(DEPTH);
            short_q <= 1'b0;
        end else begin
            if (wr_en)      wr_ptr  <= nxt_ptr;
            if (window_adv) lim_ptr <= lim_ptr + PTRW'(HALF);
            if (poison_en)  short_q <= 1'b1;
        end
    end

    // R8
    incomplete_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (short_q && !restart) |=> short_q);

    // R8
    incomplete_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(short_q) |-> $past(src_valid && src_last));

    // R9
    restart_window_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (wr_ptr == '0 && lim_ptr == PTRW'(DEPTH) && !short_q));

endmodule

// File: rtl/sb_drain_track.sv
module sb_drain_track #(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned IDXW = $clog2(DEPTH),
    localparam int unsigned HALF = DEPTH / 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            restart,
    input  logic            rd_req,
    input  logic            drain_ack,
    output logic            rd_fire,
    output logic [IDXW-1:0] rd_addr,
    output logic            rd_valid,
    output logic            window_adv,
    output logic            half_evt,
    output logic            full_evt,
    output logic            overrun
);

    logic [IDXW-1:0] rd_idx;
    logic half_q, full_q, over_q, valid_q;
    logic set_half, set_full, ack_ok, clr_half, clr_full, half_n, full_n;

    assign rd_fire  = rd_req && !over_q && !restart;
    assign set_half = rd_fire && (rd_idx == IDXW'(HALF - 1));
    assign set_full = rd_fire && (rd_idx == IDXW'(DEPTH - 1));
    assign ack_ok   = drain_ack && !over_q && !restart && (half_q || full_q);
    assign clr_half = ack_ok && half_q;
    assign clr_full = ack_ok && !half_q && full_q;
    assign half_n   = (half_q && !clr_half) || set_half;
    assign full_n   = (full_q && !clr_full) || set_full;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            rd_idx  <= '0;
            half_q  <= 1'b0;
            full_q  <= 1'b0;
            over_q  <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            if (rd_fire) rd_idx <= rd_idx + IDXW'(1);
            half_q  <= half_n;
            full_q  <= full_n;
            over_q  <= over_q || (half_n && full_n);
            valid_q <= rd_fire;
        end
    end

    assign rd_addr    = rd_idx;
    assign rd_valid   = valid_q;
    assign window_adv = ack_ok;
    assign half_evt   = half_q;
    assign full_evt   = full_q;
    assign overrun    = over_q;

    // R5
    half_from_read_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(half_q) |-> $past(rd_req && rd_idx == IDXW'(HALF - 1)));

    // R5
    full_from_read_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(full_q) |-> $past(rd_req && rd_idx == IDXW'(DEPTH - 1)));

    // R6
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (over_q && !restart) |=> over_q);

    // R6
    overrun_blocks_read_chk: assert property (@(posedge clk) disable iff (rst)
        over_q |=> !valid_q);

endmodule

// File: rtl/bus_word_stager.sv
module bus_word_stager
    import stagebuf_pkg::*;
#(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned IDXW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              src_valid,
    input  logic [BYTE_W-1:0] src_byte,
    input  logic              src_last,
    output logic              src_ready,
    input  logic              drain_ack,
    input  logic              restart,
    input  logic              rd_req,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_word,
    output logic              half_evt,
    output logic              full_evt,
    output logic              overrun,
    output logic              incomplete
);

    logic            wr_en, poison_en, rd_fire, window_adv;
    logic [IDXW-1:0] wr_addr, poison_addr, rd_addr;
    bus_word_t       rd_w;

    sb_fill_ctrl #(.DEPTH(DEPTH)) u_fill (
        .clk        (clk),
        .rst        (rst),
        .restart    (restart),
        .aborted    (overrun),
        .window_adv (window_adv),
        .src_valid  (src_valid),
        .src_last   (src_last),
        .src_ready  (src_ready),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .poison_en  (poison_en),
        .poison_addr(poison_addr),
        .incomplete (incomplete)
    );

    sb_drain_track #(.DEPTH(DEPTH)) u_drain (
        .clk        (clk),
        .rst        (rst),
        .restart    (restart),
        .rd_req     (rd_req),
        .drain_ack  (drain_ack),
        .rd_fire    (rd_fire),
        .rd_addr    (rd_addr),
        .rd_valid   (rd_valid),
        .window_adv (window_adv),
        .half_evt   (half_evt),
        .full_evt   (full_evt),
        .overrun    (overrun)
    );

    sb_ring #(.DEPTH(DEPTH)) u_ring (
        .clk     (clk),
        .wa_en   (wr_en),
        .wa_addr (wr_addr),
        .wa_word (encode_byte(src_byte)),
        .wb_en   (poison_en),
        .wb_addr (poison_addr),
        .wb_word (poison_word()),
        .rd_en   (rd_fire),
        .rd_addr (rd_addr),
        .rd_word (rd_w)
    );

    assign rd_word = rd_w;

    // R7
    poison_follows_last_chk: assert property (@(posedge clk) disable iff (rst)
        poison_en |-> (src_valid && src_last && src_ready && poison_addr != wr_addr));

    // R6
    overrun_stops_source_chk: assert property (@(posedge clk) disable iff (rst)
        overrun |-> !src_ready);

endmodule

// File: tb/bus_word_stager_test.sv
module bus_word_stager_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       src_valid = 1'b0, src_last = 1'b0, drain_ack = 1'b0, restart = 1'b0, rd_req = 1'b0;
    logic [7:0] src_byte = 8'h00;
    logic       src_ready, rd_valid, half_evt, full_evt, overrun, incomplete;
    logic [8:0] rd_word;

    int nvec = 0;
    int nbad = 0;
    logic [8:0] mring [256];
    int bwr = 0;
    int brd = 0;

    always #2 clk = ~clk;

    bus_word_stager uut (
        .clk(clk), .rst(rst), .src_valid(src_valid), .src_byte(src_byte),
        .src_last(src_last), .src_ready(src_ready), .drain_ack(drain_ack),
        .restart(restart), .rd_req(rd_req), .rd_valid(rd_valid), .rd_word(rd_word),
        .half_evt(half_evt), .full_evt(full_evt), .overrun(overrun),
        .incomplete(incomplete)
    );

    function automatic logic [8:0] benc(input logic [7:0] b);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += int'(b[i]);
        return {((ones % 2) == 0), b};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b, input logic last, output logic acc);
        @(negedge clk);
        src_valid = 1'b1; src_byte = b; src_last = last;
        acc = src_ready;
        if (acc) begin
            mring[bwr % 256] = benc(b);
            bwr++;
        end
        @(posedge clk);
        #1 src_valid = 1'b0; src_last = 1'b0;
    endtask

    task automatic pull(output logic v, output logic [8:0] w);
        @(negedge clk);
        rd_req = 1'b1;
        @(posedge clk);
        #1 rd_req = 1'b0;
        @(negedge clk);
        v = rd_valid; w = rd_word;
    endtask

    task automatic pull_chk(input string req);
        logic v; logic [8:0] w;
        pull(v, w);
        chk(v == 1'b1, req, int'(v), 1);
        chk(w == mring[brd % 256], req, int'(w), int'(mring[brd % 256]));
        brd++;
    endtask

    task automatic pulse_ack();
        @(negedge clk); drain_ack = 1'b1;
        @(posedge clk); #1 drain_ack = 1'b0;
    endtask

    task automatic pulse_restart();
        @(negedge clk); restart = 1'b1;
        @(posedge clk); #1 restart = 1'b0;
        bwr = 0; brd = 0;
    endtask

    task automatic fill_count(input int tries, input int last_at, output int n);
        logic a;
        n = 0;
        for (int i = 0; i < tries; i++) begin
            push(8'($urandom), (i == last_at), a);
            if (a) n++;
        end
    endtask

    initial begin
        #(4 * 200000);
        nbad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        int n;
        logic a, v;
        logic [8:0] w;
        void'($urandom(32'd4021));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(src_ready == 1'b1, "R1", int'(src_ready), 1);
        chk(rd_valid == 1'b0, "R1", int'(rd_valid), 0);
        chk(!half_evt && !full_evt, "R1", int'({half_evt, full_evt}), 0);
        chk(overrun == 1'b0, "R1", int'(overrun), 0);
        chk(incomplete == 1'b0, "R1", int'(incomplete), 0);

        // R3 exactly one ring worth is taken
        fill_count(260, -1, n);
        chk(n == 256, "R3", n, 256);
        chk(src_ready == 1'b0, "R3", int'(src_ready), 0);

        // R10 ack without pending flag leaves limit
        pulse_ack();
        push(8'h5a, 1'b0, a);
        chk(a == 1'b0, "R10", int'(a), 0);

        // R2 R5 first half drained
        for (int i = 0; i < 128; i++) begin
            pull_chk("R2");
            if (i == 126) chk(half_evt == 1'b0, "R5", int'(half_evt), 0);
        end
        chk(half_evt == 1'b1, "R5", int'(half_evt), 1);
        chk(full_evt == 1'b0, "R5", int'(full_evt), 0);
        pulse_ack();
        @(negedge clk);
        chk(half_evt == 1'b0, "R5", int'(half_evt), 0);

        // R4 window moved by half a ring
        fill_count(140, -1, n);
        chk(n == 128, "R4", n, 128);

        // R5 second half drained
        for (int i = 0; i < 128; i++) pull_chk("R2");
        chk(full_evt == 1'b1, "R5", int'(full_evt), 1);
        chk(half_evt == 1'b0, "R5", int'(half_evt), 0);
        pulse_ack();
        @(negedge clk);
        chk(full_evt == 1'b0, "R5", int'(full_evt), 0);

        // R11 wrap to slot 0
        for (int i = 0; i < 128; i++) pull_chk("R11");
        chk(half_evt == 1'b1, "R11", int'(half_evt), 1);
        pulse_ack();

        // R8 short refill of 10 bytes
        fill_count(10, 9, n);
        chk(n == 10, "R8", n, 10);
        @(negedge clk);
        chk(incomplete == 1'b1, "R8", int'(incomplete), 1);
        chk(src_ready == 1'b0, "R8", int'(src_ready), 0);
        pulse_ack();
        push(8'hc3, 1'b0, a);
        chk(a == 1'b0, "R8", int'(a), 0);

        // R7 poison word after last byte
        for (int i = 0; i < 10; i++) pull_chk("R7");
        pull(v, w);
        chk(w == 9'h000, "R7", int'(w), 0);
        chk(incomplete == 1'b1, "R8", int'(incomplete), 1);

        // R9 restart
        pulse_restart();
        @(negedge clk);
        chk(incomplete == 1'b0, "R9", int'(incomplete), 0);
        chk(!half_evt && !full_evt && !overrun, "R9", int'({half_evt, full_evt, overrun}), 0);
        chk(src_ready == 1'b1, "R9", int'(src_ready), 1);
        fill_count(5, -1, n);
        for (int i = 0; i < 5; i++) pull_chk("R9");

        // R3 R8 last byte exactly on the limit
        fill_count(251, 250, n);
        chk(n == 251, "R3", n, 251);
        @(negedge clk);
        chk(incomplete == 1'b0, "R8", int'(incomplete), 0);
        chk(src_ready == 1'b0, "R3", int'(src_ready), 0);
        pulse_ack();
        push(8'h11, 1'b0, a);
        chk(a == 1'b0, "R10", int'(a), 0);

        // R6 lap without service
        for (int i = 0; i < 123; i++) pull_chk("R2");
        chk(half_evt == 1'b1, "R6", int'(half_evt), 1);
        for (int i = 0; i < 127; i++) pull(v, w);
        chk(overrun == 1'b0, "R6", int'(overrun), 0);
        pull(v, w);
        chk(overrun == 1'b1, "R6", int'(overrun), 1);
        chk(src_ready == 1'b0, "R6", int'(src_ready), 0);
        pull(v, w);
        chk(v == 1'b0, "R6", int'(v), 0);
        pulse_ack();
        @(negedge clk);
        chk(overrun == 1'b1 && half_evt, "R6", int'({overrun, half_evt}), 3);
        pulse_restart();
        @(negedge clk);
        chk(overrun == 1'b0, "R9", int'(overrun), 0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule